// File: doc/BRIEF.md
# Trap Entry State Updater

This block takes a processor from normal execution into a trap handler in a single clock cycle. A one-cycle request arrives with a flag that marks it as an interrupt or an exception, a cause code, the faulting address, the current program counter and the current privilege. From these inputs the block chooses the handler level. The trap goes to supervisor level when the trap is delegated and the hart is not already in machine mode. In every other case it goes to machine level.

On the next cycle the block presents the handler's program counter and the new privilege, with a one-cycle redirect strobe. It has already saved the old state into the status, cause, exception-pc and trap-value registers of the chosen level. It also raises a strobe that drops any outstanding load reservation.

Environment calls arrive with any of the three call codes, and the block rewrites the code according to the caller's privilege. The trap-value register records an address only for the exception classes that carry one. A plain write port lets the surrounding register file load the held registers. A write that lands in the same cycle as a trap is discarded.

Top module: `trap_entry_unit`

## Requirements
- R1: Privilege codes are U=00, S=01, M=11. A trap goes to supervisor level only when all three hold: the current privilege is U or S, the effective cause is below XLEN, and that cause's bit is set in `irq_deleg_i` (for interrupts) or in `exc_deleg_i` (for exceptions). Every other trap goes to machine level, and `new_priv_o` shows the chosen level.
- R2: A supervisor-level entry changes three fields of `status_o`. Bit 5 takes the old bit 1, bit 8 becomes 1 exactly when the old privilege was S, and bit 1 is cleared. The machine-level fields do not change.
- R3: A machine-level entry changes three fields of `status_o`. Bit 7 takes the old bit 3, bits 12:11 take the old privilege, and bit 3 is cleared. The supervisor-level fields do not change.
- R4: The target level's cause register receives the effective cause in its low bits, with bit XLEN-1 set only for interrupts. Its exception-pc register receives `cur_pc_i`. The other level's registers keep their values.
- R5: The new pc is the target level's vector with bits 1:0 cleared. When the vector's bits 1:0 equal 01 and the trap is an interrupt, 4 times the cause is added. Exceptions never receive the offset.
- R6: The target level's trap-value register receives `trap_addr_i` only for exceptions with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. For all other exceptions and for every interrupt it receives zero.
- R7: An exception with input cause 8, 9 or 11 is an environment call. Its effective cause becomes 8 from U, 9 from S and 11 from M, and this value is used for delegation and is the value recorded.
- R8: `redirect_o` and `resv_clear_o` are high for exactly the one cycle after each trap request and low otherwise. Every trap entry clears the reservation.
- R9: After reset, `new_priv_o` is M, `new_pc_o` is RESET_PC, every held register is zero and both strobes are low.
- R10: When `csr_we_i` is high, the register picked by `csr_sel_i` is loaded: 0 status, 1 mcause, 2 mepc, 3 mtval, 4 scause, 5 sepc, 6 stval. A status write keeps only bits 1, 3, 5, 7, 8 and 12:11. A write in the same cycle as a trap request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req_i | input | 1 | One-cycle trap request |
| trap_is_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | CAUSE_W | Raw cause code |
| trap_addr_i | input | XLEN | Faulting address |
| cur_pc_i | input | XLEN | pc of the trapping instruction |
| cur_priv_i | input | 2 | Current privilege |
| irq_deleg_i | input | XLEN | Interrupt delegation bits |
| exc_deleg_i | input | XLEN | Exception delegation bits |
| m_vec_i | input | XLEN | Machine trap vector (bits 1:0 = mode) |
| s_vec_i | input | XLEN | Supervisor trap vector (bits 1:0 = mode) |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 3 | Register select for writes |
| csr_wdata_i | input | XLEN | Write data |
| new_pc_o | output | XLEN | Handler pc |
| new_priv_o | output | 2 | Privilege after entry |
| redirect_o | output | 1 | Fetch redirect strobe |
| resv_clear_o | output | 1 | Load reservation invalidate |
| status_o | output | XLEN | Status register |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception pc |
| mtval_o | output | XLEN | Machine trap value |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception pc |
| stval_o | output | XLEN | Supervisor trap value |

## Verification
A trap entry and a register write can fall in the same cycle, and both want the status register. The bench provokes this with a trap from machine mode while a write of zero to the status register is also presented. It then judges the result against the trap's stacking rule applied to the earlier status value. A write that had taken effect would leave zero, so it would be caught. The interaction of the remapped environment-call code with delegation is judged the same way. Each call is routed by its remapped code, not by the code that arrived.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_MCAUSE = 3'd1,
    SEL_MEPC   = 3'd2,
    SEL_MTVAL  = 3'd3,
    SEL_SCAUSE = 3'd4,
    SEL_SEPC   = 3'd5,
    SEL_STVAL  = 3'd6,
    SEL_NONE   = 3'd7
  } csr_sel_e;

  // status field positions
  localparam int unsigned ST_SIE  = 1;
  localparam int unsigned ST_MIE  = 3;
  localparam int unsigned ST_SPIE = 5;
  localparam int unsigned ST_MPIE = 7;
  localparam int unsigned ST_SPP  = 8;
  localparam int unsigned ST_MPP  = 11;

  // exception causes that record an address (bits 0..15)
  localparam logic [15:0] ADDR_CAUSE_MASK = 16'hB0F3;

endpackage

// File: rtl/trap_router.sv
module trap_router #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] raw_cause,
  input  logic [1:0]         priv,
  input  logic [XLEN-1:0]    irq_deleg,
  input  logic [XLEN-1:0]    exc_deleg,
  output logic [CAUSE_W-1:0] eff_cause,
  output logic               to_super
);
  import trap_entry_pkg::*;

  localparam int unsigned IDX_W = $clog2(XLEN);

  function automatic logic [CAUSE_W-1:0] remap_ecall(
    input logic irq, input logic [CAUSE_W-1:0] c, input logic [1:0] p);
    logic [CAUSE_W-1:0] r;
    r = c;
    if (!irq && (c == CAUSE_W'(8) || c == CAUSE_W'(9) || c == CAUSE_W'(11))) begin
      case (p)
        PRIV_U:  r = CAUSE_W'(8);
        PRIV_S:  r = CAUSE_W'(9);
        default: r = CAUSE_W'(11);
      endcase
    end
    return r;
  endfunction

  logic            in_range;
  logic            low_priv;
  logic [XLEN-1:0] deleg_sel;

  always_comb begin
    eff_cause = remap_ecall(is_irq, raw_cause, priv);
    in_range  = (eff_cause >> IDX_W) == '0;
    low_priv  = (priv == PRIV_U) || (priv == PRIV_S);
    deleg_sel = is_irq ? irq_deleg : exc_deleg;
    to_super  = low_priv && in_range && deleg_sel[eff_cause[IDX_W-1:0]];
  end

endmodule

// File: rtl/trap_target_calc.sv
module trap_target_calc #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] eff_cause,
  input  logic               to_super,
  input  logic [XLEN-1:0]    m_vec,
  input  logic [XLEN-1:0]    s_vec,
  input  logic [XLEN-1:0]    fault_addr,
  output logic [XLEN-1:0]    tgt_pc,
  output logic [XLEN-1:0]    tval_val,
  output logic [XLEN-1:0]    cause_word
);
  import trap_entry_pkg::*;

  function automatic logic [XLEN-1:0] vector_pc(
    input logic [XLEN-1:0] vec, input logic irq, input logic [CAUSE_W-1:0] c);
    logic [XLEN-1:0] base;
    base = {vec[XLEN-1:2], 2'b00};
    if (irq && vec[1:0] == 2'b01) base = base + (XLEN'(c) << 2);
    return base;
  endfunction

  function automatic logic keeps_addr(input logic irq, input logic [CAUSE_W-1:0] c);
    return !irq && ((c >> 4) == '0) && ADDR_CAUSE_MASK[c[3:0]];
  endfunction

  always_comb begin
    tgt_pc     = vector_pc(to_super ? s_vec : m_vec, is_irq, eff_cause);
    tval_val   = keeps_addr(is_irq, eff_cause) ? fault_addr : '0;
    cause_word = {is_irq, (XLEN-1)'(eff_cause)};
  end

endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs #(
  parameter int unsigned   XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_fire,
  input  logic            to_super,
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cause_word,
  input  logic [XLEN-1:0] tval_val,
  input  logic [XLEN-1:0] tgt_pc,
  input  logic            csr_we,
  input  logic [2:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] pc_q,
  output logic [1:0]      priv_q,
  output logic            redirect_q,
  output logic            resv_clr_q,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] mcause_q,
  output logic [XLEN-1:0] mepc_q,
  output logic [XLEN-1:0] mtval_q,
  output logic [XLEN-1:0] scause_q,
  output logic [XLEN-1:0] sepc_q,
  output logic [XLEN-1:0] stval_q
);
  import trap_entry_pkg::*;

  localparam logic [XLEN-1:0] STATUS_MASK =
    (XLEN'(1) << ST_SIE)  | (XLEN'(1) << ST_MIE) | (XLEN'(1) << ST_SPIE) |
    (XLEN'(1) << ST_MPIE) | (XLEN'(1) << ST_SPP) | (XLEN'(3) << ST_MPP);

  csr_sel_e sel;
  assign sel = csr_sel_e'(csr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q       <= RESET_PC;
      priv_q     <= PRIV_M;
      redirect_q <= 1'b0;
      resv_clr_q <= 1'b0;
      status_q   <= '0;
      mcause_q   <= '0;
      mepc_q     <= '0;
      mtval_q    <= '0;
      scause_q   <= '0;
      sepc_q     <= '0;
      stval_q    <= '0;
    end else begin
      redirect_q <= trap_fire;
      resv_clr_q <= trap_fire;
      if (trap_fire) begin
        pc_q <= tgt_pc;
        if (to_super) begin
          priv_q             <= PRIV_S;
          scause_q           <= cause_word;
          sepc_q             <= cur_pc;
          stval_q            <= tval_val;
          status_q[ST_SPIE]  <= status_q[ST_SIE];
          status_q[ST_SPP]   <= (cur_priv == PRIV_S);
          status_q[ST_SIE]   <= 1'b0;
        end else begin
          priv_q                    <= PRIV_M;
          mcause_q                  <= cause_word;
          mepc_q                    <= cur_pc;
          mtval_q                   <= tval_val;
          status_q[ST_MPIE]         <= status_q[ST_MIE];
          status_q[ST_MPP+1:ST_MPP] <= cur_priv;
          status_q[ST_MIE]          <= 1'b0;
        end
      end else if (csr_we) begin
        case (sel)
          SEL_STATUS: status_q <= csr_wdata & STATUS_MASK;
          SEL_MCAUSE: mcause_q <= csr_wdata;
          SEL_MEPC:   mepc_q   <= csr_wdata;
          SEL_MTVAL:  mtval_q  <= csr_wdata;
          SEL_SCAUSE: scause_q <= csr_wdata;
          SEL_SEPC:   sepc_q   <= csr_wdata;
          SEL_STVAL:  stval_q  <= csr_wdata;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     CAUSE_W  = 6,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req_i,
  input  logic               trap_is_irq_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_addr_i,
  input  logic [XLEN-1:0]    cur_pc_i,
  input  logic [1:0]         cur_priv_i,
  input  logic [XLEN-1:0]    irq_deleg_i,
  input  logic [XLEN-1:0]    exc_deleg_i,
  input  logic [XLEN-1:0]    m_vec_i,
  input  logic [XLEN-1:0]    s_vec_i,
  input  logic               csr_we_i,
  input  logic [2:0]         csr_sel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    new_pc_o,
  output logic [1:0]         new_priv_o,
  output logic               redirect_o,
  output logic               resv_clear_o,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    mtval_o,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    sepc_o,
  output logic [XLEN-1:0]    stval_o
);

  // named internal events, visible to the checker
  logic [CAUSE_W-1:0] eff_cause;
  logic               route_super;
  logic [XLEN-1:0]    tgt_pc;
  logic [XLEN-1:0]    tval_val;
  logic [XLEN-1:0]    cause_word;

  trap_router #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_router (
    .is_irq    (trap_is_irq_i),
    .raw_cause (trap_cause_i),
    .priv      (cur_priv_i),
    .irq_deleg (irq_deleg_i),
    .exc_deleg (exc_deleg_i),
    .eff_cause (eff_cause),
    .to_super  (route_super)
  );

  trap_target_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_target (
    .is_irq     (trap_is_irq_i),
    .eff_cause  (eff_cause),
    .to_super   (route_super),
    .m_vec      (m_vec_i),
    .s_vec      (s_vec_i),
    .fault_addr (trap_addr_i),
    .tgt_pc     (tgt_pc),
    .tval_val   (tval_val),
    .cause_word (cause_word)
  );

  trap_state_regs #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_fire  (trap_req_i),
    .to_super   (route_super),
    .cur_priv   (cur_priv_i),
    .cur_pc     (cur_pc_i),
    .cause_word (cause_word),
    .tval_val   (tval_val),
    .tgt_pc     (tgt_pc),
    .csr_we     (csr_we_i),
    .csr_sel    (csr_sel_i),
    .csr_wdata  (csr_wdata_i),
    .pc_q       (new_pc_o),
    .priv_q     (new_priv_o),
    .redirect_q (redirect_o),
    .resv_clr_q (resv_clear_o),
    .status_q   (status_o),
    .mcause_q   (mcause_o),
    .mepc_q     (mepc_o),
    .mtval_q    (mtval_o),
    .scause_q   (scause_o),
    .sepc_q     (sepc_o),
    .stval_q    (stval_o)
  );

endmodule

// File: rtl/trap_entry_sva.sv
module trap_entry_sva #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req_i,
  input logic            trap_is_irq_i,
  input logic [1:0]      cur_priv_i,
  input logic [XLEN-1:0] cur_pc_i,
  input logic            route_super,
  input logic [1:0]      new_priv_o,
  input logic [XLEN-1:0] new_pc_o,
  input logic            redirect_o,
  input logic            resv_clear_o,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] sepc_o,
  input logic [XLEN-1:0] mtval_o,
  input logic [XLEN-1:0] stval_o
);

  AST_TRAP_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_i |=> (redirect_o && resv_clear_o)); // R8

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req_i |=> (!redirect_o && !resv_clear_o)); // R8

  AST_M_NEVER_DELEGATES: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && cur_priv_i == 2'b11) |-> !route_super); // R1

  AST_SUPER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && route_super) |=> (new_priv_o == 2'b01 && !status_o[1])); // R2

  AST_MACHINE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && !route_super) |=> (new_priv_o == 2'b11 && !status_o[3])); // R3

  AST_MEPC_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && !route_super) |=> mepc_o == $past(cur_pc_i)); // R4

  AST_SEPC_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && route_super) |=> sepc_o == $past(cur_pc_i)); // R4

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_i |=> new_pc_o[1:0] == 2'b00); // R5

  AST_IRQ_NO_MTVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && trap_is_irq_i && !route_super) |=> mtval_o == '0); // R6

  AST_IRQ_NO_STVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && trap_is_irq_i && route_super) |=> stval_o == '0); // R6

endmodule

bind trap_entry_unit trap_entry_sva #(.XLEN(XLEN)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .trap_req_i    (trap_req_i),
  .trap_is_irq_i (trap_is_irq_i),
  .cur_priv_i    (cur_priv_i),
  .cur_pc_i      (cur_pc_i),
  .route_super   (route_super),
  .new_priv_o    (new_priv_o),
  .new_pc_o      (new_pc_o),
  .redirect_o    (redirect_o),
  .resv_clear_o  (resv_clear_o),
  .status_o      (status_o),
  .mepc_o        (mepc_o),
  .sepc_o        (sepc_o),
  .mtval_o       (mtval_o),
  .stval_o       (stval_o)
);

// File: tb/trap_entry_unit_tb.sv
`timescale 1ns/1ps
module trap_entry_unit_tb;

  localparam int unsigned XLEN = 32;
  localparam int unsigned CW   = 6;
  localparam logic [31:0] M_BASE = 32'h8000_0100;
  localparam logic [31:0] S_BASE = 32'h4000_0200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 0, is_irq = 0, csr_we = 0;
  logic [CW-1:0] cause = '0;
  logic [31:0] addr = '0, pc = '0, ideleg = '0, edeleg = '0, mvec = '0, svec = '0, wdata = '0;
  logic [1:0] priv = '0;
  logic [2:0] sel = '0;
  logic [31:0] new_pc, status, mcause, mepc, mtval, scause, sepc, stval;
  logic [1:0] new_priv;
  logic redirect, resv_clear;

  always #2 clk = ~clk;

  trap_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req), .trap_is_irq_i(is_irq),
    .trap_cause_i(cause), .trap_addr_i(addr), .cur_pc_i(pc), .cur_priv_i(priv),
    .irq_deleg_i(ideleg), .exc_deleg_i(edeleg), .m_vec_i(mvec), .s_vec_i(svec),
    .csr_we_i(csr_we), .csr_sel_i(sel), .csr_wdata_i(wdata),
    .new_pc_o(new_pc), .new_priv_o(new_priv), .redirect_o(redirect),
    .resv_clear_o(resv_clear), .status_o(status), .mcause_o(mcause), .mepc_o(mepc),
    .mtval_o(mtval), .scause_o(scause), .sepc_o(sepc), .stval_o(stval)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic          irq;
    logic [5:0]    cause;
    logic [1:0]    priv;
    logic [1:0]    del;    // 0 none, 1 all ones, 2 all but own bit, 3 only the other register
    logic          vmode;
    logic [1:0]    xpriv;
    logic [5:0]    xcause;
    logic          xtval;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd2,  2'd0, 2'd1, 1'b0, 2'd1, 6'd2,  1'b0}, // R1 delegated illegal op from U
    '{1'b0, 6'd13, 2'd1, 2'd1, 1'b0, 2'd1, 6'd13, 1'b1}, // R1 R6 page fault from S
    '{1'b0, 6'd13, 2'd3, 2'd1, 1'b0, 2'd3, 6'd13, 1'b1}, // R1 M never delegates
    '{1'b0, 6'd5,  2'd0, 2'd0, 1'b0, 2'd3, 6'd5,  1'b1}, // R1 no delegation
    '{1'b0, 6'd2,  2'd0, 2'd2, 1'b0, 2'd3, 6'd2,  1'b0}, // R1 only other bits set
    '{1'b0, 6'd2,  2'd0, 2'd3, 1'b0, 2'd3, 6'd2,  1'b0}, // R1 wrong register set
    '{1'b1, 6'd7,  2'd0, 2'd0, 1'b1, 2'd3, 6'd7,  1'b0}, // R5 vectored irq to M
    '{1'b1, 6'd5,  2'd1, 2'd1, 1'b1, 2'd1, 6'd5,  1'b0}, // R5 vectored irq to S
    '{1'b1, 6'd9,  2'd0, 2'd1, 1'b0, 2'd1, 6'd9,  1'b0}, // R5 direct mode irq
    '{1'b0, 6'd5,  2'd0, 2'd0, 1'b1, 2'd3, 6'd5,  1'b1}, // R5 exception ignores vector mode
    '{1'b0, 6'd8,  2'd1, 2'd0, 1'b0, 2'd3, 6'd9,  1'b0}, // R7 ecall from S
    '{1'b0, 6'd11, 2'd0, 2'd1, 1'b0, 2'd1, 6'd8,  1'b0}, // R7 ecall from U delegated
    '{1'b0, 6'd9,  2'd3, 2'd1, 1'b0, 2'd3, 6'd11, 1'b0}, // R7 ecall from M
    '{1'b0, 6'd40, 2'd0, 2'd1, 1'b0, 2'd3, 6'd40, 1'b0}, // R1 cause beyond XLEN
    '{1'b1, 6'd3,  2'd3, 2'd1, 1'b1, 2'd3, 6'd3,  1'b0}, // R5 irq in M
    '{1'b0, 6'd0,  2'd1, 2'd0, 1'b0, 2'd3, 6'd0,  1'b1}, // R6 misaligned fetch
    '{1'b0, 6'd3,  2'd0, 2'd1, 1'b0, 2'd1, 6'd3,  1'b0}, // R6 breakpoint has no address
    '{1'b1, 6'd13, 2'd0, 2'd0, 1'b0, 2'd3, 6'd13, 1'b0}  // R6 irq code 13 has no address
  };

  task automatic fire_trap(input logic i, input logic [CW-1:0] c, input logic [1:0] p,
                           input logic [31:0] dpc, input logic [31:0] da);
    @(negedge clk);
    is_irq = i; cause = c; priv = p; pc = dpc; addr = da; trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
  endtask

  task automatic csr_write(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(new_priv == 2'b11, "R9 priv", {30'd0, new_priv}, 32'd3);
    chk(new_pc == 32'd0, "R9 pc", new_pc, 32'd0);
    chk(status == 0 && mcause == 0 && scause == 0 && mepc == 0 && sepc == 0, "R9 regs", status, 32'd0);
    chk(!redirect && !resv_clear, "R9 strobes", {30'd0, redirect, resv_clear}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] one, base, exp_pc, exp_cause, exp_tval, tpc, taddr, got_cause, got_epc, got_tval;
      v = VECS[i];
      one = (v.xcause < 32) ? (32'd1 << v.xcause[4:0]) : 32'd0;
      case (v.del)
        2'd0: begin ideleg = '0; edeleg = '0; end
        2'd1: begin ideleg = '1; edeleg = '1; end
        2'd2: begin ideleg = ~one; edeleg = ~one; end
        default: begin ideleg = v.irq ? 32'd0 : '1; edeleg = v.irq ? '1 : 32'd0; end
      endcase
      mvec = M_BASE | {31'd0, v.vmode};
      svec = S_BASE | {31'd0, v.vmode};
      tpc = 32'h0000_1000 + 32'(i) * 16;
      taddr = 32'hDEAD_BE00 + 32'(i);
      base = (v.xpriv == 2'd1) ? S_BASE : M_BASE;
      exp_pc = base + ((v.vmode && v.irq) ? (32'(v.xcause) << 2) : 32'd0);
      exp_cause = {v.irq, 25'd0, v.xcause};
      exp_tval = v.xtval ? taddr : 32'd0;
      fire_trap(v.irq, v.cause, v.priv, tpc, taddr);
      got_cause = (v.xpriv == 2'd1) ? scause : mcause;
      got_epc   = (v.xpriv == 2'd1) ? sepc : mepc;
      got_tval  = (v.xpriv == 2'd1) ? stval : mtval;
      chk(new_priv == v.xpriv, "R1 target level", {30'd0, new_priv}, {30'd0, v.xpriv});
      chk(new_pc == exp_pc, "R5 new pc", new_pc, exp_pc);
      chk(got_cause == exp_cause, "R4 R7 cause", got_cause, exp_cause);
      chk(got_epc == tpc, "R4 epc", got_epc, tpc);
      chk(got_tval == exp_tval, "R6 tval", got_tval, exp_tval);
      chk(redirect && resv_clear, "R8 strobes", {30'd0, redirect, resv_clear}, 32'd3);
    end

    // R8 strobes last one cycle only
    @(negedge clk);
    chk(!redirect && !resv_clear, "R8 idle", {30'd0, redirect, resv_clear}, 32'd0);

    // R2 supervisor stacking, M registers untouched (R4)
    csr_write(3'd1, 32'h55);
    csr_write(3'd0, 32'h0000_000A);
    chk(status == 32'h0000_000A, "R10 status write", status, 32'h0000_000A);
    ideleg = '1; edeleg = '1;
    fire_trap(1'b0, 6'd2, 2'd1, 32'h2000, 32'h0);
    chk(status == 32'h0000_0128, "R2 supervisor stack", status, 32'h0000_0128);
    chk(mcause == 32'h55, "R4 other level kept", mcause, 32'h55);

    // R3 machine stacking from S
    ideleg = '0; edeleg = '0;
    fire_trap(1'b0, 6'd2, 2'd1, 32'h2004, 32'h0);
    chk(status == 32'h0000_09A0, "R3 machine stack", status, 32'h0000_09A0);

    // R10 masked status write
    csr_write(3'd0, 32'hFFFF_FFFF);
    chk(status == 32'h0000_19AA, "R10 status mask", status, 32'h0000_19AA);
    csr_write(3'd2, 32'h1234_5678);
    chk(mepc == 32'h1234_5678, "R10 mepc write", mepc, 32'h1234_5678);

    // R10 trap and write in the same cycle: the write is dropped
    @(negedge clk);
    is_irq = 1'b0; cause = 6'd3; priv = 2'd3; pc = 32'h3000; addr = 32'h0;
    trap_req = 1'b1; csr_we = 1'b1; sel = 3'd0; wdata = 32'd0;
    @(negedge clk);
    trap_req = 1'b0; csr_we = 1'b0;
    chk(status == 32'h0000_19A2, "R10 R3 collision status", status, 32'h0000_19A2);
    chk(mcause == 32'd3, "R10 collision cause", mcause, 32'd3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule